// File: doc/BRIEF.md
# Serially Addressed Crosspoint Switch Controller

This block is the control logic for a 2-input by 8-output crosspoint array. It keeps 16 switch-enable bits, one per input/output pairing, and drives them straight out to the external switch devices. A host loads a short command over a two-wire serial link: a serial clock and a data line. The host then raises either of two enable lines. On that rising edge the addressed crosspoint is connected or disconnected, and every other crosspoint holds its state.

A build parameter selects the command length. The default adds a sixth bit to each command. When that bit and the data bit are both zero, the command clears the whole array in one step. All four serial and enable inputs arrive without a known timing relation to the system clock. The block passes each of them through a two-stage synchroniser and detects their edges in the system clock domain.

Top module: `xbar_switch_ctrl`

## Requirements
- R1: A synchronous reset (rst_n low at a rising clk edge) clears all 16 switch outputs and the command register to zero.
- R2: With both enable inputs low, each falling edge of sclk_in shifts sdata_in into the command register. Bits go in as D first, then Y0, X2, X1 and X0, then R (the sixth bit, default build only).
- R3: When more than one word's worth of falling edges arrive, only the last 6 bits shifted in (5 without the clear bit) make up the command.
- R4: Falling edges of sclk_in are ignored while either enable input is high, and the command register keeps its contents.
- R5: A rising edge on ena_in, on enb_in, or on both at once applies the stored command exactly once. Falling enable edges change nothing.
- R6: A command with D=1 connects the addressed switch and one with D=0 disconnects it. All other switches are unchanged.
- R7: Y0=1 selects input A and Y0=0 selects input B. The output number minus one equals X xor 3'b010. Switch bit = 8*(not Y0) + (X xor 3'b010), so bits 0..7 are input A to outputs 1..8 and bits 8..15 are input B. For example, D,Y0,X2,X1,X0 = 1,1,1,1,0 connects A to output 5 (bit 4).
- R8: In the default build, a command with D=0 and R=0 clears all 16 switches on the enable rising edge.
- R9: In the default build, a command with D=1 and R=0 leaves every switch unchanged.
- R10: If an enable input rises just before rising clk edge n, sw_state keeps its old value through edge n+1 and shows the new value after edge n+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_in | input | 1 | Serial clock; data is taken on its falling edge |
| sdata_in | input | 1 | Serial command data |
| ena_in | input | 1 | Enable line A; low to load, rising edge to apply |
| enb_in | input | 1 | Enable line B; same function as ena_in |
| sw_state | output | 16 | Switch-enable bits, 1 = connected |

## Verification
If the command register holds a wrong bit, the wrong switch moves or the wrong direction is applied. This shows on sw_state three clock cycles after the next enable rising edge. An error in the address decode sets a bit other than the expected one, so the bench drives all 16 addresses in both directions and checks the full 16-bit vector each time. Shifting while an enable is high, or applying a command on a falling edge, is invisible until a later enable edge reapplies the stored word. The bench therefore issues such an edge with no new bits in between.

// File: rtl/xbar_pkg.sv
// Package: shared constants and the address-to-switch mapping of the
// crosspoint controller. Assumes a fixed 2 x 8 array with 3 output-select bits.
package xbar_pkg;
    localparam int XB_INPUTS   = 2;
    localparam int XB_OUTPUTS  = 8;
    localparam int XB_SWITCHES = XB_INPUTS * XB_OUTPUTS;
    localparam int XB_IDX_W    = $clog2(XB_SWITCHES);

    // Map the input-select bit and output-select field to a switch bit index.
    function automatic logic [XB_IDX_W-1:0] sw_index(input logic y0, input logic [2:0] xsel);
        return {~y0, xsel ^ 3'b010};
    endfunction
endpackage

// File: rtl/xbar_sync.sv
// Module: multi-bit synchroniser chain. Each bit passes STAGES flops.
// Assumes the bits are independent (no bus coherency needed).
module xbar_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/xbar_cmd_shift.sv
// Module: serial command register. On each shift strobe it takes one bit
// at the LSB, so the first bit sent ends up at the MSB and older bits fall off.
// Assumes the strobe is a single-cycle pulse in the clk domain.
module xbar_cmd_shift #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word_q
);
    // Keep only the most recent W bits.
    always_ff @(posedge clk) begin
        if (!rst_n)        word_q <= '0;
        else if (shift_en) word_q <= {word_q[W-2:0], din};
    end
endmodule

// File: rtl/xbar_switch_bank.sv
// Module: bank of switch-enable latches. A clear pulse zeroes all of them.
// An apply pulse writes 'conn' into the one latch chosen by 'sel'.
// Assumes apply and clear are never high together.
module xbar_switch_bank #(
    parameter int N     = 16,
    parameter int SEL_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             apply,
    input  logic             clear,
    input  logic             conn,
    input  logic [SEL_W-1:0] sel,
    output logic [N-1:0]     state_q
);
    for (genvar g = 0; g < N; g++) begin : g_sw
        // One latch per crosspoint: hold until addressed or cleared.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)                     state_q[g] <= 1'b0;
            else if (apply && sel == SEL_W'(g))      state_q[g] <= conn;
        end
    end
endmodule

// File: rtl/xbar_switch_ctrl.sv
// Module: top of the crosspoint controller. It synchronises the serial and
// enable inputs, shifts command bits on serial clock falls while both enables
// are low, and applies the stored command on any enable rising edge.
// Assumes the inputs are asynchronous to clk and slow compared with it.
module xbar_switch_ctrl #(
    parameter bit CLEAR_EN    = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk_in,
    input  logic        sdata_in,
    input  logic        ena_in,
    input  logic        enb_in,
    output logic [15:0] sw_state
);
    import xbar_pkg::*;

    localparam int WORD_W = CLEAR_EN ? 6 : 5;
    localparam int MSB    = WORD_W - 1;

    logic [3:0]        sync_vec;
    logic              sclk_s, data_s, ena_s, enb_s;
    logic              sclk_prev, ena_prev, enb_prev;
    logic              en_low, shift_evt, en_rise;
    logic [WORD_W-1:0] word_q;
    logic              cmd_d, cmd_y;
    logic [2:0]        cmd_x;
    logic              clr_word, hold_word;
    logic              do_apply, do_clear;

    xbar_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sclk_in, sdata_in, ena_in, enb_in}),
        .dout (sync_vec)
    );
    assign {sclk_s, data_s, ena_s, enb_s} = sync_vec;

    // Delayed copies for edge detection in the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) {sclk_prev, ena_prev, enb_prev} <= '0;
        else        {sclk_prev, ena_prev, enb_prev} <= {sclk_s, ena_s, enb_s};
    end

    assign en_low    = ~ena_s & ~enb_s;
    assign shift_evt = sclk_prev & ~sclk_s & en_low;
    assign en_rise   = (ena_s & ~ena_prev) | (enb_s & ~enb_prev);

    xbar_cmd_shift #(.W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_evt),
        .din     (data_s),
        .word_q  (word_q)
    );

    assign cmd_d = word_q[MSB];
    assign cmd_y = word_q[MSB-1];
    assign cmd_x = word_q[MSB-2 -: 3];

    if (CLEAR_EN) begin : g_clr
        assign clr_word  = ~cmd_d & ~word_q[0];
        assign hold_word =  cmd_d & ~word_q[0];
    end else begin : g_noclr
        assign clr_word  = 1'b0;
        assign hold_word = 1'b0;
    end

    assign do_clear = en_rise & clr_word;
    assign do_apply = en_rise & ~clr_word & ~hold_word;

    xbar_switch_bank #(.N(XB_SWITCHES)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .apply  (do_apply),
        .clear  (do_clear),
        .conn   (cmd_d),
        .sel    (sw_index(cmd_y, cmd_x)),
        .state_q(sw_state)
    );
endmodule

// File: rtl/xbar_switch_ctrl_chk.sv
// Module: assertion checker bound into xbar_switch_ctrl. It watches the edge
// events, the command register and the switch outputs.
module xbar_switch_ctrl_chk #(
    parameter int WORD_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_rise,
    input logic              en_low,
    input logic              shift_evt,
    input logic              data_s,
    input logic              do_apply,
    input logic              do_clear,
    input logic [WORD_W-1:0] word_q,
    input logic [15:0]       sw_state
);
    // R5: switches move only after an enable rising edge.
    assert_stable_no_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_rise |=> $stable(sw_state));

    // R6: a single update touches at most one switch.
    assert_one_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        do_apply |=> $countones(sw_state ^ $past(sw_state)) <= 1);

    // R8: the clear word empties the array.
    assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        do_clear |=> sw_state == 16'h0000);

    // R2: a shift places the synchronised data bit at the register LSB.
    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_evt |=> word_q[0] == $past(data_s));

    // R4: the command register holds while any enable is high.
    assert_no_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_low |=> $stable(word_q));
endmodule

bind xbar_switch_ctrl xbar_switch_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_rise  (en_rise),
    .en_low   (en_low),
    .shift_evt(shift_evt),
    .data_s   (data_s),
    .do_apply (do_apply),
    .do_clear (do_clear),
    .word_q   (word_q),
    .sw_state (sw_state)
);

// File: tb/xbar_switch_ctrl_tb.sv
// Directed bench for xbar_switch_ctrl (default build, 6-bit commands).
module xbar_switch_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b0, sdata_in = 1'b0, ena_in = 1'b0, enb_in = 1'b0;
    logic [15:0] sw_state;
    logic [15:0] exp_sw = '0;
    int          n_checks = 0, n_errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    xbar_switch_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_in(sdata_in),
        .ena_in(ena_in), .enb_in(enb_in), .sw_state(sw_state)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // Command word per R2/R7: {D, Y0, X2..X0, R}; Y0=1 is input A.
    function automatic logic [5:0] mk(input logic d, input int idx, input logic r);
        logic       y0 = (idx < 8);
        logic [2:0] x  = 3'(idx % 8) ^ 3'b010;
        return {d, y0, x, r};
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [15:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdata_in = bits[i];
            sclk_in  = 1'b1;
            wait_clk(4);
            sclk_in  = 1'b0;
            wait_clk(4);
        end
    endtask

    // Pulse an enable (0 = A, 1 = B, 2 = both) and let the result settle.
    task automatic pulse_en(input int which);
        if (which != 1) ena_in = 1'b1;
        if (which != 0) enb_in = 1'b1;
        wait_clk(5);
        ena_in = 1'b0;
        enb_in = 1'b0;
        wait_clk(5);
    endtask

    task automatic t_reset;
        check("R1 reset state", sw_state, 16'h0000);
    endtask

    task automatic t_example;
        send_bits(16'b111101, 6);
        pulse_en(0);
        exp_sw[4] = 1'b1;
        check("R7 A to output 5 is bit 4", sw_state, exp_sw);
        send_bits(16'b011101, 6);
        pulse_en(1);
        exp_sw[4] = 1'b0;
        check("R6 disconnect A-5", sw_state, exp_sw);
    endtask

    task automatic t_all_addresses;
        for (int k = 0; k < 16; k++) begin
            send_bits(16'(mk(1'b1, k, 1'b1)), 6);
            pulse_en(k % 3);
            exp_sw[k] = 1'b1;
            check($sformatf("R7 R6 connect switch %0d", k), sw_state, exp_sw);
        end
        for (int k = 0; k < 16; k++) begin
            send_bits(16'(mk(1'b0, k, 1'b1)), 6);
            pulse_en(k % 2);
            exp_sw[k] = 1'b0;
            check($sformatf("R7 R6 disconnect switch %0d", k), sw_state, exp_sw);
        end
    endtask

    task automatic t_latency;
        send_bits(16'(mk(1'b1, 9, 1'b1)), 6);
        ena_in = 1'b1;
        wait_clk(2);
        check("R10 unchanged after two edges", sw_state, exp_sw);
        wait_clk(1);
        exp_sw[9] = 1'b1;
        check("R10 updated on third edge", sw_state, exp_sw);
        ena_in = 1'b0;
        wait_clk(5);
        check("R5 falling enable no effect", sw_state, exp_sw);
    endtask

    task automatic t_overlong;
        send_bits({7'b1010011, 3'b000, mk(1'b1, 2, 1'b1)}, 16);
        pulse_en(0);
        exp_sw[2] = 1'b1;
        check("R3 last six bits kept", sw_state, exp_sw);
    endtask

    task automatic t_ignored_while_high;
        send_bits(16'(mk(1'b1, 13, 1'b1)), 6);
        pulse_en(1);
        exp_sw[13] = 1'b1;
        check("R4 setup connect 13", sw_state, exp_sw);
        ena_in = 1'b1;
        wait_clk(5);
        send_bits(16'(mk(1'b0, 13, 1'b1)), 6);
        ena_in = 1'b0;
        wait_clk(5);
        pulse_en(0);
        check("R4 bits with enable high ignored", sw_state, exp_sw);
    endtask

    task automatic t_both_edges;
        send_bits(16'(mk(1'b1, 7, 1'b1)), 6);
        pulse_en(2);
        exp_sw[7] = 1'b1;
        check("R5 both enables rise together", sw_state, exp_sw);
        ena_in = 1'b1;
        wait_clk(5);
        enb_in = 1'b1;
        wait_clk(5);
        ena_in = 1'b0;
        enb_in = 1'b0;
        wait_clk(5);
        check("R5 second enable rising reapplies same word", sw_state, exp_sw);
    endtask

    task automatic t_hold_word;
        send_bits(16'(mk(1'b1, 0, 1'b0)), 6);
        pulse_en(0);
        check("R9 D=1 R=0 changes nothing", sw_state, exp_sw);
    endtask

    task automatic t_clear_word;
        check("R8 array not empty before clear", 16'(sw_state != 16'h0000), 16'h0001);
        send_bits(16'(mk(1'b0, 5, 1'b0)), 6);
        pulse_en(1);
        exp_sw = '0;
        check("R8 clear word empties array", sw_state, exp_sw);
    endtask

    task automatic t_reset_mid;
        send_bits(16'(mk(1'b1, 11, 1'b1)), 6);
        pulse_en(0);
        exp_sw[11] = 1'b1;
        check("R1 setup before reset", sw_state, exp_sw);
        rst_n = 1'b0;
        wait_clk(2);
        rst_n = 1'b1;
        wait_clk(2);
        exp_sw = '0;
        check("R1 reset clears switches", sw_state, exp_sw);
        pulse_en(0);
        check("R1 reset cleared command register", sw_state, exp_sw);
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_example();
        t_all_addresses();
        t_latency();
        t_overlong();
        t_ignored_while_high();
        t_both_edges();
        t_hold_word();
        t_clear_word();
        t_reset_mid();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule